// File: doc/BRIEF.md
# Indirect Address RAM Window

This block gives byte-wide access to a 14-byte internal RAM through a single data location per region. The RAM holds two regions: a 6-byte station address and an 8-byte multicast hash filter. A configuration location holds an address-change flag and two region-select flags. Software writes a select flag. It then issues consecutive accesses to the matching data location, and an internal pointer steps through that region one byte per access. Once the region's last byte has been touched, the select flag clears by itself.

Every access is presented on a plain request port (`acc_valid`, location, direction, write data). It completes in the cycle it is presented. There is no back-pressure: the block is always ready. In that same cycle the block answers with `acc_ack` and, for an acknowledged read, `acc_rdata`. An access to a location that is not currently open gets no acknowledge and has no effect.

Location codes on `acc_loc`: 0 is the configuration location, 1 is the station address data location, 2 is the hash filter data location, and 3 is unused.

Top module: `addr_ram_window`

## Requirements
- R1: An access to location 0 is always acknowledged. A read of location 0 returns bit 7 as the stored change flag, bit 2 as 1 while the station region is open, bit 1 as 1 while the filter region is open, and all other bits as 0.
- R2: A write to location 0 with bit 1 set opens the filter region at its byte 0, whether or not bit 2 is also set.
- R3: A write to location 0 with bit 2 set and bit 1 clear opens the station region at its byte 0.
- R4: A write to location 0 with bits 1 and 2 both clear closes any open region. Bit 7 of every write to location 0 is stored as the change flag, in the same cycle as the select bits.
- R5: An acknowledged write to the open region's data location stores the byte at the pointer's position. An acknowledged read returns the byte at that position. The station region occupies RAM bytes 0 to 5 and the filter region occupies bytes 6 to 13.
- R6: Every acknowledged data access, read or write, advances the pointer by exactly one byte.
- R7: The station select clears on its 6th data access and the filter select clears on its 8th. The very next data access then gets no acknowledge.
- R8: A data access to the region that is not open (location 1 while the filter region is open, or location 2 while the station region is open) gets no acknowledge. It does not advance the pointer and does not change the RAM.
- R9: With no region open, data accesses are not acknowledged and leave the RAM unchanged. Location 3 is never acknowledged.
- R10: `acc_rdata` is 0 unless an acknowledged read is in progress. After reset no region is open, the change flag is 0 and every RAM byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request present this cycle |
| acc_loc | input | 2 | Location: 0 config, 1 station data, 2 filter data, 3 unused |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 8 | Write byte |
| acc_ack | output | 1 | Data-transfer-valid acknowledge, same cycle |
| acc_rdata | output | 8 | Read byte, 0 when not an acknowledged read |

## Verification
The assertions assume that every request is held for one clock and is consumed at that edge. They also assume that `acc_loc` and `acc_write` are known whenever `acc_valid` is high. The stimulus meets this by changing inputs only on the falling edge and dropping `acc_valid` after each access. Random traffic biases configuration writes toward setting select bits, so that both regions run to their self-clear point many times. It also mixes cross-region and unused-location accesses into open windows, so that the no-effect cases are seen mid-region rather than only at the ends.

// File: rtl/arw_pkg.sv
package arw_pkg;
  typedef enum logic [1:0] {
    LOC_CFG  = 2'd0,
    LOC_STA  = 2'd1,
    LOC_FLT  = 2'd2,
    LOC_NONE = 2'd3
  } loc_e;

  typedef enum logic [1:0] {
    WIN_IDLE = 2'd0,
    WIN_STA  = 2'd1,
    WIN_FLT  = 2'd2
  } win_e;

  localparam int CHG_BIT = 7;
  localparam int STA_BIT = 2;
  localparam int FLT_BIT = 1;
endpackage

// File: rtl/arw_decode.sv
module arw_decode
  import arw_pkg::*;
(
  input  logic       acc_valid,
  input  logic [1:0] acc_loc,
  input  logic       acc_write,
  input  win_e       win,
  output logic       ack,
  output logic       cfg_wr,
  output logic       data_hit,
  output logic       rd_en
);
  logic sta_ok, flt_ok, cfg_hit;

  always_comb begin
    cfg_hit  = acc_valid && (acc_loc == LOC_CFG);
    sta_ok   = acc_valid && (acc_loc == LOC_STA) && (win == WIN_STA);
    flt_ok   = acc_valid && (acc_loc == LOC_FLT) && (win == WIN_FLT);
    data_hit = sta_ok || flt_ok;
    ack      = cfg_hit || data_hit;
    cfg_wr   = cfg_hit && acc_write;
    rd_en    = ack && !acc_write;
  end
endmodule

// File: rtl/arw_ptr_ctrl.sv
module arw_ptr_ctrl
  import arw_pkg::*;
#(
  parameter int STA_LEN = 6,
  parameter int FLT_LEN = 8,
  localparam int MAX_LEN = (STA_LEN > FLT_LEN) ? STA_LEN : FLT_LEN,
  localparam int PTR_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_chg_in,
  input  logic             cfg_sta_in,
  input  logic             cfg_flt_in,
  input  logic             data_hit,
  output win_e             win,
  output logic [PTR_W-1:0] ptr,
  output logic             chg
);
  logic [PTR_W-1:0] last_idx;

  always_comb begin
    last_idx = (win == WIN_FLT) ? PTR_W'(FLT_LEN - 1) : PTR_W'(STA_LEN - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win <= WIN_IDLE;
      ptr <= '0;
      chg <= 1'b0;
    end else if (cfg_wr) begin
      chg <= cfg_chg_in;
      ptr <= '0;
      if (cfg_flt_in)      win <= WIN_FLT;
      else if (cfg_sta_in) win <= WIN_STA;
      else                 win <= WIN_IDLE;
    end else if (data_hit) begin
      if (ptr == last_idx) begin
        win <= WIN_IDLE;
        ptr <= '0;
      end else begin
        ptr <= ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/arw_ram.sv
module arw_ram #(
  parameter int DEPTH = 14,
  parameter int DW = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/addr_ram_window.sv
module addr_ram_window
  import arw_pkg::*;
#(
  parameter int STA_LEN = 6,
  parameter int FLT_LEN = 8,
  localparam int DEPTH = STA_LEN + FLT_LEN,
  localparam int AW = $clog2(DEPTH),
  localparam int MAX_LEN = (STA_LEN > FLT_LEN) ? STA_LEN : FLT_LEN,
  localparam int PTR_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_valid,
  input  logic [1:0] acc_loc,
  input  logic       acc_write,
  input  logic [7:0] acc_wdata,
  output logic       acc_ack,
  output logic [7:0] acc_rdata
);
  win_e             win;
  logic [PTR_W-1:0] ptr;
  logic             chg;
  logic             cfg_wr, data_hit, rd_en;
  logic [AW-1:0]    ram_addr;
  logic [7:0]       ram_q, cfg_q;

  arw_decode u_dec (
    .acc_valid(acc_valid), .acc_loc(acc_loc), .acc_write(acc_write),
    .win(win), .ack(acc_ack), .cfg_wr(cfg_wr), .data_hit(data_hit),
    .rd_en(rd_en)
  );

  arw_ptr_ctrl #(.STA_LEN(STA_LEN), .FLT_LEN(FLT_LEN)) u_ptr (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
    .cfg_chg_in(acc_wdata[CHG_BIT]), .cfg_sta_in(acc_wdata[STA_BIT]),
    .cfg_flt_in(acc_wdata[FLT_BIT]), .data_hit(data_hit),
    .win(win), .ptr(ptr), .chg(chg)
  );

  always_comb begin
    ram_addr = (win == WIN_FLT) ? AW'(STA_LEN) + AW'(ptr) : AW'(ptr);
    cfg_q = '0;
    cfg_q[CHG_BIT] = chg;
    cfg_q[STA_BIT] = (win == WIN_STA);
    cfg_q[FLT_BIT] = (win == WIN_FLT);
  end

  arw_ram #(.DEPTH(DEPTH), .DW(8)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(data_hit && acc_write),
    .addr(ram_addr), .wdata(acc_wdata), .rdata(ram_q)
  );

  always_comb begin
    if (!rd_en)                   acc_rdata = '0;
    else if (acc_loc == LOC_CFG)  acc_rdata = cfg_q;
    else                          acc_rdata = ram_q;
  end
endmodule

// File: rtl/addr_ram_window_chk.sv
module addr_ram_window_chk
  import arw_pkg::*;
#(
  parameter int STA_LEN = 6,
  parameter int FLT_LEN = 8,
  parameter int PTR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic [1:0]       acc_loc,
  input logic             acc_write,
  input logic [7:0]       acc_wdata,
  input logic             acc_ack,
  input logic [7:0]       acc_rdata,
  input win_e             win,
  input logic [PTR_W-1:0] ptr
);
  logic data_acc, at_last;
  assign data_acc = acc_valid && acc_ack && (acc_loc != LOC_CFG);
  assign at_last  = (win == WIN_FLT) ? (ptr == PTR_W'(FLT_LEN - 1))
                                     : (ptr == PTR_W'(STA_LEN - 1));

  // R1
  cfg_always_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_loc == LOC_CFG) |-> acc_ack);

  // R2
  flt_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_loc == LOC_CFG && acc_write && acc_wdata[FLT_BIT])
    |=> (win == WIN_FLT && ptr == '0));

  // R3
  sta_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_loc == LOC_CFG && acc_write && acc_wdata[STA_BIT] &&
     !acc_wdata[FLT_BIT]) |=> (win == WIN_STA && ptr == '0));

  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !at_last) |=> (ptr == PTR_W'($past(ptr) + 1'b1) && $stable(win)));

  // R7
  self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && at_last) |=> (win == WIN_IDLE));

  // R8
  cross_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && ((acc_loc == LOC_STA && win == WIN_FLT) ||
                   (acc_loc == LOC_FLT && win == WIN_STA))) |-> !acc_ack);

  // R8
  no_ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_ack) |=> ($stable(ptr) && $stable(win)));

  // R9
  idle_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (acc_loc == LOC_NONE ||
                   (acc_loc != LOC_CFG && win == WIN_IDLE))) |-> !acc_ack);

  // R10
  rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_ack && !acc_write) |-> (acc_rdata == 8'h00));
endmodule

bind addr_ram_window addr_ram_window_chk #(
  .STA_LEN(STA_LEN), .FLT_LEN(FLT_LEN), .PTR_W(PTR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_loc(acc_loc),
  .acc_write(acc_write), .acc_wdata(acc_wdata), .acc_ack(acc_ack),
  .acc_rdata(acc_rdata), .win(win), .ptr(ptr)
);

// File: tb/addr_ram_window_bench.sv
module addr_ram_window_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0;
  logic [1:0] acc_loc = 2'd0;
  logic       acc_write = 1'b0;
  logic [7:0] acc_wdata = 8'h00;
  logic       acc_ack;
  logic [7:0] acc_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference state built from the requirements
  logic [7:0] m_ram [14];
  int         m_win = 0;   // 0 idle, 1 station, 2 filter
  int         m_ptr = 0;
  logic       m_chg = 1'b0;

  always #10 clk = ~clk;

  addr_ram_window u_addr_ram_window (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_loc(acc_loc),
    .acc_write(acc_write), .acc_wdata(acc_wdata), .acc_ack(acc_ack),
    .acc_rdata(acc_rdata)
  );

  function automatic logic exp_ack(input logic [1:0] loc);
    if (loc == 2'd0) return 1'b1;
    if (loc == 2'd1) return m_win == 1;
    if (loc == 2'd2) return m_win == 2;
    return 1'b0;
  endfunction

  function automatic logic [7:0] exp_rdata(input logic [1:0] loc, input logic wr);
    if (!exp_ack(loc) || wr) return 8'h00;
    if (loc == 2'd0) return {m_chg, 4'b0000, m_win == 1, m_win == 2, 1'b0};
    return m_ram[(m_win == 2 ? 6 : 0) + m_ptr];
  endfunction

  function automatic string auto_tag(input logic [1:0] loc);
    if (loc == 2'd0) return "R1";
    if (loc == 2'd3 || m_win == 0) return "R9";
    if (exp_ack(loc)) return "R5";
    return "R8";
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic do_acc(input logic [1:0] loc, input logic wr, input logic [7:0] d,
                        input string tag);
    string t;
    logic ea;
    logic [7:0] er;
    @(negedge clk);
    acc_valid = 1'b1; acc_loc = loc; acc_write = wr; acc_wdata = d;
    t  = (tag == "") ? auto_tag(loc) : tag;
    ea = exp_ack(loc);
    er = exp_rdata(loc, wr);
    #2;
    check(t, "ack", int'(acc_ack), int'(ea));
    check((er != 0) ? t : "R10", "rdata", int'(acc_rdata), int'(er));
    @(posedge clk);
    if (ea) begin
      if (loc == 2'd0) begin
        if (wr) begin
          m_chg = d[7];
          m_ptr = 0;
          m_win = d[1] ? 2 : (d[2] ? 1 : 0);
        end
      end else begin
        if (wr) m_ram[(m_win == 2 ? 6 : 0) + m_ptr] = d;
        if (m_ptr == ((m_win == 2) ? 7 : 5)) begin
          m_win = 0; m_ptr = 0;
        end else m_ptr++;
      end
    end
    #1 acc_valid = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 14; i++) m_ram[i] = 8'h00;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state (R10)
    do_acc(2'd0, 1'b0, 8'h00, "R10");
    do_acc(2'd1, 1'b0, 8'h00, "R10");
    do_acc(2'd3, 1'b1, 8'h55, "R9");

    // both bits with change flag: filter wins (R2, R4)
    do_acc(2'd0, 1'b1, 8'h86, "R2");
    do_acc(2'd0, 1'b0, 8'h00, "R2");
    do_acc(2'd1, 1'b1, 8'hEE, "R8");
    for (int i = 0; i < 8; i++) begin
      do_acc(2'd2, 1'b1, 8'hA0 + 8'(i), "R6");
      if (i == 6) do_acc(2'd0, 1'b0, 8'h00, "R7");
    end
    do_acc(2'd0, 1'b0, 8'h00, "R7");
    do_acc(2'd2, 1'b0, 8'h00, "R7");

    // station region, mixed reads and writes (R3, R5, R6)
    do_acc(2'd0, 1'b1, 8'h04, "R3");
    for (int i = 0; i < 6; i++) do_acc(2'd1, 1'b1, 8'h10 + 8'(i), "R5");
    do_acc(2'd1, 1'b0, 8'h00, "R7");
    do_acc(2'd0, 1'b1, 8'h04, "R3");
    for (int i = 0; i < 6; i++) begin
      do_acc(2'd1, i[0], 8'h30 + 8'(i), "R6");
      if (i == 2) do_acc(2'd2, 1'b1, 8'hFF, "R8");
    end
    do_acc(2'd0, 1'b1, 8'h02, "R2");
    for (int i = 0; i < 8; i++) do_acc(2'd2, 1'b0, 8'h00, "R5");

    // closing a window mid-region (R4)
    do_acc(2'd0, 1'b1, 8'h84, "R4");
    do_acc(2'd1, 1'b0, 8'h00, "R4");
    do_acc(2'd0, 1'b1, 8'h00, "R4");
    do_acc(2'd0, 1'b0, 8'h00, "R4");
    do_acc(2'd1, 1'b1, 8'h77, "R9");

    // constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] loc;
      logic       wr;
      logic [7:0] d;
      int r;
      r   = int'($urandom_range(0, 99));
      loc = (r < 15) ? 2'd0 : (r < 55) ? 2'd1 : (r < 95) ? 2'd2 : 2'd3;
      wr  = 1'($urandom);
      d   = 8'($urandom);
      if (loc == 2'd0 && wr && ($urandom_range(0, 3) != 0))
        d[2:1] = ($urandom_range(0, 1) != 0) ? 2'b10 : 2'b01;
      do_acc(loc, wr, d, "");
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule